// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits on the device side of a byte-wide command channel and gives a host access to a small set of internal 8-bit registers. Every command byte has a 4-bit opcode in bits 7:4 and a 4-bit payload in bits 3:0. A register address and a write value are each built up from two separate nibble commands. Only the command that carries the upper data nibble performs the write. A read command returns exactly one response byte.

Three registers are mapped. The identity register at address 0x00 always reads 0xA6. The scratch register at address 0x01 reads back the last value written to it. The mode register at address 0x02 drives the `mode_value` output, and its bit 0 requests initialization of an external memory. The host normally reads the identity register, writes and reads back a scratch pattern, and then writes the mode register.

Top module: `nib_reg_decoder`

## Requirements
- R1: After reset the response valid is low and `mode_value` is 0x00. The assembled address and the scratch register are 0x00, so the first read returns 0xA6 and a read of address 0x01 returns 0x00.
- R2: Opcode 0x0 loads bits 3:0 of the address from the payload and leaves bits 7:4 unchanged. Opcode 0x1 loads bits 7:4 and leaves bits 3:0 unchanged.
- R3: Opcode 0x2 stores the payload as the pending low data nibble and changes no register. Opcode 0x3 writes {payload, pending low nibble} to the current address.
- R4: Each accepted read (opcode 0x4) produces `rsp_valid` high for exactly the one cycle after the command is accepted. Back-to-back reads give back-to-back pulses.
- R5: The identity register at address 0x00 reads 0xA6, and writes to it are ignored.
- R6: The scratch register at address 0x01 returns the last byte written to it, for example 0x55 and then 0xAA.
- R7: The address and the pending low data nibble persist across commands. A later write or read reuses them without being resent.
- R8: The mode register at address 0x02 takes the written byte. It is visible on `mode_value` one cycle after the write and is returned by a read. Bit 0 is the memory-initialization request.
- R9: A read of an unmapped address (anything other than 0x00 to 0x02) returns 0x00. A write to an unmapped address changes nothing.
- R10: Opcodes 0x5 to 0xF, and any byte with `cmd_valid` low, change no state and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command byte qualifier |
| cmd_byte | input | 8 | Command: opcode in bits 7:4, payload in bits 3:0 |
| rsp_valid | output | 1 | One-cycle pulse marking a response byte |
| rsp_byte | output | 8 | Response data, valid while `rsp_valid` is high |
| mode_value | output | 8 | Current mode register contents |

## Verification
The hardest case to reach is a register change that should not happen, such as an uncommitted low nibble, a write to the identity register, or a write to an unmapped address. None of these shows on any port until a later read. The stimulus therefore follows each such command with a return to a mapped address and a read. It also compares `mode_value` after every command. Reads that leave the address unchanged, issued after ignored opcodes, show that neither the address nor the register contents moved.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_WRITE   = 4'h3,
    OP_READ    = 4'h4
  } nrd_op_e;

  typedef struct packed {
    logic set_alo;
    logic set_ahi;
    logic set_dlo;
    logic commit;
    logic read;
  } nrd_ctrl_t;

endpackage

// File: rtl/nrd_rst_sync.sv
module nrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/nrd_cmd_decode.sv
module nrd_cmd_decode
  import nrd_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output nrd_ctrl_t         ctrl,
  output logic [NIB_W-1:0]  nib
);

  logic [NIB_W-1:0] opcode;

  assign opcode = cmd_byte[BYTE_W-1:NIB_W];
  assign nib    = cmd_byte[NIB_W-1:0];

  always_comb begin
    ctrl = '0;
    if (cmd_valid) begin
      case (opcode)
        OP_ADDR_LO: ctrl.set_alo = 1'b1;
        OP_ADDR_HI: ctrl.set_ahi = 1'b1;
        OP_DATA_LO: ctrl.set_dlo = 1'b1;
        OP_WRITE:   ctrl.commit  = 1'b1;
        OP_READ:    ctrl.read    = 1'b1;
        default:    ctrl = '0;
      endcase
    end
  end

  // R10: at most one action per command
  always_comb begin
    a_r10_single_action: assert ($onehot0(ctrl));
  end

endmodule

// File: rtl/nrd_addr_data.sv
module nrd_addr_data
  import nrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nrd_ctrl_t         ctrl,
  input  logic [NIB_W-1:0]  nib,
  output logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              wr_en
);

  localparam int NUM_NIB = BYTE_W / NIB_W;

  logic [NIB_W-1:0] dlo_q, dlo_d;
  logic [NUM_NIB-1:0] nib_sel;

  assign nib_sel = {ctrl.set_ahi, ctrl.set_alo};

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_addr_nib
    logic [NIB_W-1:0] a_q, a_d;

    always_comb begin
      a_d = a_q;
      if (nib_sel[g]) a_d = nib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q <= '0;
      else        a_q <= a_d;
    end

    assign addr[g*NIB_W +: NIB_W] = a_q;
  end

  always_comb begin
    dlo_d = dlo_q;
    if (ctrl.set_dlo) dlo_d = nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dlo_q <= '0;
    else        dlo_q <= dlo_d;
  end

  assign wdata = {nib, dlo_q};
  assign wr_en = ctrl.commit;

  // R2: loading the high nibble keeps the low nibble
  a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.set_ahi |=> addr[NIB_W-1:0] == $past(addr[NIB_W-1:0]));

  // R7: address and pending nibble hold when no loading command arrives
  a_r7_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.set_alo || ctrl.set_ahi || ctrl.set_dlo) |=> ($stable(addr) && $stable(dlo_q)));

endmodule

// File: rtl/nrd_reg_file.sv
module nrd_reg_file
  import nrd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE  = 8'hA6,
  parameter logic [BYTE_W-1:0] ID_ADDR   = 8'h00,
  parameter logic [BYTE_W-1:0] SCR_ADDR  = 8'h01,
  parameter logic [BYTE_W-1:0] MODE_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] mode_q
);

  logic [BYTE_W-1:0] scr_q, scr_d, mode_d;
  logic scr_we, mode_we;

  assign scr_we  = wr_en && (addr == SCR_ADDR);
  assign mode_we = wr_en && (addr == MODE_ADDR);

  always_comb begin
    scr_d  = scr_we  ? wdata : scr_q;
    mode_d = mode_we ? wdata : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q  <= '0;
      mode_q <= '0;
    end else begin
      scr_q  <= scr_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    if (addr == ID_ADDR)        rd_data = ID_VALUE;
    else if (addr == SCR_ADDR)  rd_data = scr_q;
    else if (addr == MODE_ADDR) rd_data = mode_q;
    else                        rd_data = '0;
  end

  // R6: scratch takes the committed byte
  a_r6_scratch_take: assert property (@(posedge clk) disable iff (!rst_n)
    scr_we |=> scr_q == $past(wdata));

  // R8: mode register changes only by a write to its address
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q));

endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder
  import nrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic [7:0] mode_value
);

  logic              srst_n;
  nrd_ctrl_t         ctrl;
  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] addr, wdata, rd_data, mode_q;
  logic              wr_en;
  logic              rv_q, rv_d;
  logic [BYTE_W-1:0] rb_q, rb_d;

  nrd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  nrd_cmd_decode u_dec (
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ctrl(ctrl), .nib(nib)
  );

  nrd_addr_data u_ad (
    .clk(clk), .rst_n(srst_n), .ctrl(ctrl), .nib(nib),
    .addr(addr), .wdata(wdata), .wr_en(wr_en)
  );

  nrd_reg_file u_rf (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .mode_q(mode_q)
  );

  always_comb begin
    rv_d = ctrl.read;
    rb_d = ctrl.read ? rd_data : rb_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rv_q <= 1'b0;
      rb_q <= '0;
    end else begin
      rv_q <= rv_d;
      rb_q <= rb_d;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_byte   = rb_q;
  assign mode_value = mode_q;

  // R4: an accepted read yields a pulse on the next cycle
  a_r4_read_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_valid && cmd_byte[7:4] == 4'h4) |=> rsp_valid);

  // R4: no response without a read
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!srst_n)
    !(cmd_valid && cmd_byte[7:4] == 4'h4) |=> !rsp_valid);

endmodule

// File: tb/sim_nib_reg_decoder.sv
module sim_nib_reg_decoder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 29;

  // {req, cmd, exp_valid, exp_byte, exp_mode}
  localparam logic [28:0] VEC [NV] = '{
    {4'd1,  8'h40, 1'b1, 8'hA6, 8'h00}, // R1 first read hits ID at address 0
    {4'd2,  8'h01, 1'b0, 8'h00, 8'h00}, // R2 addr lo = 1
    {4'd3,  8'h25, 1'b0, 8'h00, 8'h00}, // R3 data lo = 5
    {4'd3,  8'h35, 1'b0, 8'h00, 8'h00}, // R3 commit 0x55
    {4'd6,  8'h40, 1'b1, 8'h55, 8'h00}, // R6
    {4'd3,  8'h2A, 1'b0, 8'h00, 8'h00},
    {4'd3,  8'h3A, 1'b0, 8'h00, 8'h00}, // commit 0xAA
    {4'd7,  8'h40, 1'b1, 8'hAA, 8'h00}, // R7 address reused
    {4'd3,  8'h2F, 1'b0, 8'h00, 8'h00}, // low nibble only
    {4'd3,  8'h40, 1'b1, 8'hAA, 8'h00}, // R3 no commit happened
    {4'd2,  8'h10, 1'b0, 8'h00, 8'h00},
    {4'd2,  8'h00, 1'b0, 8'h00, 8'h00}, // address 0x00
    {4'd5,  8'h33, 1'b0, 8'h00, 8'h00}, // write 0x3F to ID
    {4'd5,  8'h40, 1'b1, 8'hA6, 8'h00}, // R5 ID unchanged
    {4'd2,  8'h02, 1'b0, 8'h00, 8'h00}, // address 0x02
    {4'd3,  8'h21, 1'b0, 8'h00, 8'h00},
    {4'd8,  8'h38, 1'b0, 8'h00, 8'h81}, // R8 mode = 0x81
    {4'd8,  8'h40, 1'b1, 8'h81, 8'h81},
    {4'd2,  8'h13, 1'b0, 8'h00, 8'h81}, // address 0x32
    {4'd9,  8'h37, 1'b0, 8'h00, 8'h81}, // unmapped write 0x71
    {4'd9,  8'h40, 1'b1, 8'h00, 8'h81}, // R9 unmapped reads zero
    {4'd2,  8'h01, 1'b0, 8'h00, 8'h81}, // address 0x31
    {4'd2,  8'h10, 1'b0, 8'h00, 8'h81}, // address 0x01
    {4'd2,  8'h40, 1'b1, 8'hAA, 8'h81}, // R2 lo kept, scratch untouched
    {4'd10, 8'h5F, 1'b0, 8'h00, 8'h81}, // R10 ignored opcode
    {4'd10, 8'hF0, 1'b0, 8'h00, 8'h81},
    {4'd10, 8'h40, 1'b1, 8'hAA, 8'h81},
    {4'd4,  8'h40, 1'b1, 8'hAA, 8'h81}, // R4 back-to-back
    {4'd4,  8'h40, 1'b1, 8'hAA, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic [7:0] mode_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_reg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .mode_value(mode_value)
  );

  task automatic check(input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] c);
    cmd_valid = v;
    cmd_byte  = c;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    @(negedge clk);
    do_reset();
    check(1, "reset rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check(1, "reset mode", mode_value, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][24:17]);
      check(int'(VEC[i][28:25]), "rsp_valid", {7'd0, rsp_valid}, {7'd0, VEC[i][16]});
      if (VEC[i][16]) check(int'(VEC[i][28:25]), "rsp_byte", rsp_byte, VEC[i][15:8]);
      check(int'(VEC[i][28:25]), "mode", mode_value, VEC[i][7:0]);
    end

    // R4: pulse ends one cycle after the read
    step(1'b0, 8'h00);
    check(4, "pulse width", {7'd0, rsp_valid}, 8'h00);

    // R10: read byte with valid low gives no response
    step(1'b0, 8'h40);
    check(10, "valid low read", {7'd0, rsp_valid}, 8'h00);
    step(1'b1, 8'h40);
    check(10, "state after idle", rsp_byte, 8'hAA);

    // R1: reset mid-stream clears mode, scratch and address
    rst_n = 1'b0;
    #1;
    check(1, "async rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check(1, "async mode", mode_value, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 8'h40);
    check(1, "address back to ID", rsp_byte, 8'hA6);
    step(1'b1, 8'h01);
    step(1'b1, 8'h40);
    check(1, "scratch cleared", rsp_byte, 8'h00);

    // R8: mode bit 0 alone (memory-initialization request)
    step(1'b1, 8'h02);
    step(1'b1, 8'h21);
    step(1'b1, 8'h30);
    check(8, "init request bit", mode_value, 8'h01);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule